// File: doc/BRIEF.md
# Frequent Loop Profiler

This block sits beside a processor core and watches its branch stream without ever driving anything back toward the core. Each cycle it sees the address of the current branch, a strobe saying the branch was taken, and the branch target. A taken branch that jumps backward is treated as one more run of a loop. The loop is identified by its target address, which is its first instruction.

A small fully associative table of loop start addresses, each with a saturating frequency counter, keeps the most active loops. A known loop bumps its counter. A new loop takes the lowest free slot. When the table is full, a new loop evicts the entry with the smallest count. When a counter would overflow, every counter is halved, so the table always holds relative frequencies rather than absolute ones.

Software or a debug agent reads any entry at any time through a combinational read port. Reading never delays or loses a counting event.

Top module: `lp_profiler`

## Requirements
- R1: An event is a cycle with `br_taken` high and `br_target` strictly below `fetch_pc` (unsigned). In any other cycle (not taken, target equal to or above the branch address) the table keeps every valid flag, address and count unchanged.
- R2: During and right after reset, every entry reads back as valid 0, address 0, count 0.
- R3: An event whose target matches a valid entry, and whose count is below the all-ones maximum, adds exactly 1 to that entry's count. No other entry changes.
- R4: An event with no matching entry, while a free entry exists, fills the lowest-index free entry: valid 1, address equal to the target, count 1. Valid entries therefore always occupy indices 0 upward without gaps.
- R5: An event with no match on a full table replaces the entry with the smallest count, choosing the lowest index on a tie. That entry takes the new target address and count 1.
- R6: A hit on an entry whose count equals the all-ones maximum shifts every entry's count right by one bit. The hit entry then ends at half the maximum plus one, and addresses and valid flags are kept.
- R7: `rd_valid`, `rd_addr` and `rd_count` show entry `rd_idx` combinationally in the same cycle. Any sequence of read indices leaves the counting results unaltered.
- R8: No two valid entries ever hold the same address.
- R9: The effect of an event appears on the read port in the cycle after the clock edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address of the branch being resolved |
| br_taken | input | 1 | Branch taken strobe for this cycle |
| br_target | input | ADDR_W | Target address of the branch |
| rd_idx | input | clog2(N_ENTRIES) | Entry index to read |
| rd_valid | output | 1 | Entry holds a loop |
| rd_addr | output | ADDR_W | Loop start address of the entry |
| rd_count | output | CNT_W | Relative frequency count of the entry |

## Verification
Reading and counting are meant to overlap: an event can update an entry in the same cycle that the read port is looking at that entry, or at another one. The bench drives events every cycle while it steps `rd_idx` through the table, including the entry being hit or replaced. A behavioural table model is updated at every edge, and the read port is compared with the model's copy of the addressed entry on every clock. Any lost, doubled or misplaced update therefore shows up one cycle later.

// File: rtl/lp_pkg.sv
// Package: shared definitions for the loop profiler.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package lp_pkg;

    // Per-cycle table operation selected by the top level
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INC   = 2'd1,
        OP_HALVE = 2'd2,
        OP_ALLOC = 2'd3
    } lp_op_e;

endpackage

// File: rtl/lp_match.sv
// Associative lookup: compares a key against every valid entry.
// Assumes that at most one valid entry holds any address, so the
// OR-encoded index is exact.
module lp_match #(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 32,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0]             valid,
    input  logic [N_ENTRIES-1:0][ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0]                key,
    output logic                             hit,
    output logic [IW-1:0]                    hit_idx
);

    logic [N_ENTRIES-1:0] eq;

    // One comparator per entry
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (addr[g] == key);
    end

    // Encode the (one-hot) match vector into an index
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (eq[i]) hit_idx = hit_idx | IW'(i);
        end
    end

endmodule

// File: rtl/lp_victim.sv
// Slot chooser: finds the lowest free entry and the entry with the
// smallest count (lowest index wins ties). Assumes N_ENTRIES >= 1.
module lp_victim #(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0]            valid,
    input  logic [N_ENTRIES-1:0][CNT_W-1:0] cnt,
    output logic                            full,
    output logic [IW-1:0]                   free_idx,
    output logic [IW-1:0]                   min_idx
);

    logic             found;
    logic [CNT_W-1:0] min_val;

    // Lowest free slot
    always_comb begin
        full     = &valid;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!valid[i] && !found) begin
                free_idx = IW'(i);
                found    = 1'b1;
            end
        end
    end

    // Smallest count; strict compare keeps the lowest index on ties
    always_comb begin
        min_idx = '0;
        min_val = cnt[0];
        for (int i = 1; i < N_ENTRIES; i++) begin
            if (cnt[i] < min_val) begin
                min_val = cnt[i];
                min_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lp_table.sv
// Entry storage: valid flag, loop address and count per entry, updated
// by a single operation per cycle on one selected slot (halving touches
// all). Assumes op OP_HALVE is issued only when the slot's count is at
// its maximum.
module lp_table
    import lp_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  lp_op_e                           op,
    input  logic [IW-1:0]                    slot,
    input  logic [ADDR_W-1:0]                key,
    output logic [N_ENTRIES-1:0]             valid_q,
    output logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q,
    output logic [N_ENTRIES-1:0][CNT_W-1:0]  cnt_q
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic sel;
        assign sel = (slot == IW'(g));

        // Update one entry according to the current operation
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                cnt_q[g]   <= '0;
            end else begin
                case (op)
                    OP_INC: begin
                        if (sel) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
                    end
                    OP_HALVE: begin
                        if (sel) cnt_q[g] <= (cnt_q[g] >> 1) + CNT_W'(1);
                        else     cnt_q[g] <= cnt_q[g] >> 1;
                    end
                    OP_ALLOC: begin
                        if (sel) begin
                            valid_q[g] <= 1'b1;
                            addr_q[g]  <= key;
                            cnt_q[g]   <= CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/lp_profiler.sv
// Top level of the loop profiler. Observes the branch stream only;
// it has no output toward the processor. An event is a taken backward
// branch. Hits count, misses allocate or evict the least frequent
// entry, and saturation halves all counts. The read port is
// combinational. Assumes N_ENTRIES is a power of two.
module lp_profiler
    import lp_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [IW-1:0]     rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                             evt;
    logic                             hit;
    logic [IW-1:0]                    hit_idx;
    logic                             full;
    logic [IW-1:0]                    free_idx;
    logic [IW-1:0]                    min_idx;
    lp_op_e                           op;
    logic [IW-1:0]                    slot;
    logic [N_ENTRIES-1:0]             valid_q;
    logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [N_ENTRIES-1:0][CNT_W-1:0]  cnt_q;

    // Loop detection: taken branch going to a lower address
    assign evt = br_taken && (br_target < fetch_pc);

    lp_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) match_i (
        .valid   (valid_q),
        .addr    (addr_q),
        .key     (br_target),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    lp_victim #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) victim_i (
        .valid    (valid_q),
        .cnt      (cnt_q),
        .full     (full),
        .free_idx (free_idx),
        .min_idx  (min_idx)
    );

    // Choose this cycle's operation and target slot
    always_comb begin
        op   = OP_NONE;
        slot = full ? min_idx : free_idx;
        if (evt) begin
            if (hit) begin
                slot = hit_idx;
                op   = (cnt_q[hit_idx] == CNT_MAX) ? OP_HALVE : OP_INC;
            end else begin
                op   = OP_ALLOC;
            end
        end
    end

    lp_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .slot    (slot),
        .key     (br_target),
        .valid_q (valid_q),
        .addr_q  (addr_q),
        .cnt_q   (cnt_q)
    );

    // Combinational read port
    assign rd_valid = valid_q[rd_idx];
    assign rd_addr  = addr_q[rd_idx];
    assign rd_count = cnt_q[rd_idx];

endmodule

// File: rtl/lp_profiler_chk.sv
// Assertion checker for lp_profiler, attached with bind below.
// Observes the table state and the top level's slot decision.
module lp_profiler_chk #(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             evt,
    input logic                             hit,
    input logic [IW-1:0]                    slot,
    input logic [ADDR_W-1:0]                key,
    input logic [N_ENTRIES-1:0]             valid_q,
    input logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q,
    input logic [N_ENTRIES-1:0][CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_HALF = (CNT_MAX >> 1) + CNT_W'(1);

    // R1: no event leaves the whole table untouched
    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ($stable(valid_q) && $stable(addr_q) && $stable(cnt_q)));

    // R2: the table is empty when reset is released
    p_empty_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    // R3: a hit below maximum adds one to the hit entry
    p_hit_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && hit && cnt_q[slot] != CNT_MAX)
        |=> cnt_q[$past(slot)] == $past(cnt_q[slot]) + CNT_W'(1));

    // R4: a miss installs the target with count one
    p_new_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !hit) |=> (valid_q[$past(slot)] && cnt_q[$past(slot)] == CNT_W'(1)
                           && addr_q[$past(slot)] == $past(key)));

    // R4: valid entries form a gap-free run from index 0
    p_prefix_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q & (valid_q + N_ENTRIES'(1))) == '0);

    // R6: a hit at maximum lands on half plus one
    p_halve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && hit && cnt_q[slot] == CNT_MAX) |=> cnt_q[$past(slot)] == CNT_HALF);

    // R8: no duplicate addresses among valid entries
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                for (int j = i + 1; j < N_ENTRIES; j++) begin
                    p_unique_r8: assert (!(valid_q[i] && valid_q[j] && addr_q[i] == addr_q[j]))
                        else $error("duplicate loop address in entries %0d and %0d", i, j);
                end
            end
        end
    end

endmodule

bind lp_profiler lp_profiler_chk #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .hit     (hit),
    .slot    (slot),
    .key     (br_target),
    .valid_q (valid_q),
    .addr_q  (addr_q),
    .cnt_q   (cnt_q)
);

// File: tb/lp_profiler_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural table model updated at every edge, read port
// compared with the model's addressed entry on every clock.
module lp_profiler_tb_top;

    localparam int N  = 16;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int IW = 4;
    localparam logic [CW-1:0] MAXC = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] rd_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic          m_valid [N];
    logic [AW-1:0] m_addr  [N];
    logic [CW-1:0] m_cnt   [N];

    always #2.5 clk = ~clk;

    lp_profiler #(.N_ENTRIES(N), .ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_pc  (fetch_pc),
        .br_taken  (br_taken),
        .br_target (br_target),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_count  (rd_count)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_addr[i] = '0; m_cnt[i] = '0;
        end
    endtask

    // Behavioural update from the requirements
    task automatic model_apply(logic [AW-1:0] pc, logic tk, logic [AW-1:0] tg);
        int h = -1;
        int f = -1;
        int v = 0;
        if (!(tk && tg < pc)) return;                       // R1
        for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == tg) h = i;
        if (h >= 0) begin
            if (m_cnt[h] == MAXC) begin                     // R6
                for (int i = 0; i < N; i++) m_cnt[i] = m_cnt[i] >> 1;
                m_cnt[h] = m_cnt[h] + 1'b1;
            end else begin
                m_cnt[h] = m_cnt[h] + 1'b1;                  // R3
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) f = i;
            if (f >= 0) v = f;                               // R4
            else for (int i = 1; i < N; i++) if (m_cnt[i] < m_cnt[v]) v = i; // R5
            m_valid[v] = 1'b1; m_addr[v] = tg; m_cnt[v] = 1;
        end
    endtask

    task automatic compare(string tag);
        int i = int'(rd_idx);
        n_cmp++;
        if (rd_valid !== m_valid[i] || rd_addr !== m_addr[i] || rd_count !== m_cnt[i]) begin
            n_bad++;
            $display("FAIL %s idx %0d: got v=%0b a=%h c=%0d expected v=%0b a=%h c=%0d",
                     tag, i, rd_valid, rd_addr, rd_count, m_valid[i], m_addr[i], m_cnt[i]);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge (R9)
    task automatic tick(logic [AW-1:0] pc, logic tk, logic [AW-1:0] tg, int ridx, string tag);
        fetch_pc = pc; br_taken = tk; br_target = tg; rd_idx = IW'(ridx);
        @(posedge clk);
        if (rst_n) model_apply(pc, tk, tg); else model_reset();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < N; i++) tick('0, 1'b0, '0, i, tag);
    endtask

    // Taken backward branch to loop start a
    task automatic loop_hit(logic [AW-1:0] a, int ridx, string tag);
        tick(a + 32'h40, 1'b1, a, ridx, tag);
    endtask

    function automatic logic [AW-1:0] loop_addr(int k);
        return 32'h0000_1000 + AW'(k) * 32'h100;
    endfunction

    initial begin
        logic [15:0] lf;
        model_reset();
        @(negedge clk);
        repeat (3) tick('0, 1'b0, '0, 0, "R2 during reset");
        rst_n = 1'b1;
        sweep("R2 after reset");

        // R1: ignored branches
        tick(32'h100, 1'b1, 32'h200, 0, "R1 forward taken");
        tick(32'h100, 1'b1, 32'h100, 0, "R1 self target");
        tick(32'h300, 1'b0, 32'h100, 0, "R1 not taken");
        tick(32'h300, 1'b0, 32'h100, 0, "R1 after not taken");

        // R4 then R3 on entry 0
        loop_hit(loop_addr(0), 0, "R4 first loop");
        for (int r = 0; r < 3; r++) loop_hit(loop_addr(0), 0, "R3 repeat hit");

        // Fill the rest; entries 5 and 9 get one hit, others two
        for (int k = 1; k < N; k++) begin
            loop_hit(loop_addr(k), k, "R4 fill");
            if (k != 5 && k != 9) loop_hit(loop_addr(k), k, "R3 second hit");
        end
        sweep("R4 full table");

        // R5: evictions on full table, tie broken by lowest index
        loop_hit(loop_addr(40), 5, "R5 evict min");
        loop_hit(loop_addr(41), 5, "R5 evict tie");
        loop_hit(loop_addr(41), 5, "R3 hit after evict");
        loop_hit(loop_addr(42), 9, "R5 evict next");
        sweep("R5 table after evictions");

        // R6: drive entry 0 through saturation
        for (int r = 0; r < 260; r++) loop_hit(loop_addr(0), r % N, "R6 saturate");
        sweep("R6 after halving");

        // R7/R8/R9: mixed traffic, read index moving every cycle
        lf = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            logic [AW-1:0] t;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            t  = loop_addr(int'(lf[4:0]) % 24);
            if (lf[7:5] == 3'd0)      tick(t - 32'h4, 1'b1, t, int'(lf[11:8]), "R1 mixed forward");
            else if (lf[7:5] == 3'd1) tick(t + 32'h4, 1'b0, t, int'(lf[11:8]), "R7 mixed idle");
            else                      tick(t + 32'h4, 1'b1, t, int'(lf[11:8]), "R8 R9 mixed event");
        end
        sweep("R7 final readout");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got no completion, expected end before 200000 cycles");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule